// File: doc/BRIEF.md
# Serial Auto-Baud Boot Handshake

This block watches a serial receive line at power-up and works out the bit rate used by a host. The host sends the byte 0x00 again and again in 8N1 format. Such a byte puts the line low for nine bit times without a break: the start bit and eight zero data bits. The block counts that low stretch in system-clock cycles. It divides the count by nine to get a per-bit divisor and uses the divisor for its own transmitter and receiver.

A rate is accepted only when two qualifying low runs give divisors that agree. The block then sends a single 0x00 byte at the derived rate to tell the host that adjustment is done. After that it expects one 0x55 byte with a valid stop bit. If that byte arrives, the block raises `locked`. A wrong byte or a bad stop bit raises `error` instead. Either outcome holds until the next reset. Command traffic after the handshake is handled elsewhere.

Top module: `autobaud_boot`

## Requirements
- R1: After reset, `locked` = 0, `error` = 0, `divisor` = 0 and `txd` = 1.
- R2: A low run of N clock cycles on `rxd` gives the divisor (N + 4) / 9 in integer arithmetic, which is N/9 rounded to the nearest integer.
- R3: A low run is measured only if `rxd` was high for at least MIN_IDLE consecutive cycles just before it. This applies after reset and after every earlier run. A low run that starts without that idle time is not measured.
- R4: A run shorter than MIN_LOW cycles, or one that reaches the saturation count 2^CNT_W − 1, is ignored. The divisor stored from an earlier run is kept.
- R5: Call the stored divisor P and the new one D. The rate is accepted when |D − P| ≤ P >> 4, and `divisor` then takes D and keeps it until reset. Otherwise D replaces P and no rate is accepted.
- R6: `txd` stays high until a rate is accepted. On acceptance it sends exactly one 8N1 frame of 0x00, LSB first, with each bit lasting `divisor` cycles. On the line this is one low pulse of 9 × `divisor` cycles followed by a high level.
- R7: After the notice frame, the receiver waits for `rxd` to be high for `divisor` cycles. It then takes a start bit, samples each bit at mid-point, LSB first, and reads the stop bit. The value 0x55 with a high stop bit sets `locked`.
- R8: Any other received value, or a low stop bit, sets `error` and leaves `locked` at 0.
- R9: Once `locked` or `error` is set, it stays set until reset. `divisor` stays the same and `txd` stays high, whatever arrives on `rxd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial data from host, idle high |
| txd | output | 1 | Serial data to host, idle high |
| locked | output | 1 | Handshake completed with 0x55 |
| error | output | 1 | Confirmation byte wrong or badly framed |
| divisor | output | CNT_W-3 | Accepted clock cycles per bit, 0 before acceptance |

## Verification
The bench sends a short low glitch and an over-long low run between two valid zero bytes. A block that did not reject such runs would overwrite its stored measurement and never send the notice. It tests the agreement tolerance right at the one-count edge in both directions, and a mismatch of several counts that must cause a retry. A block with the wrong tolerance would either lock onto the first rate it saw or refuse a rate it should accept. It holds `rxd` low through the release of reset, so a block that measured without first seeing the line idle would accept a partial run one byte too early. It also sends a wrong confirmation byte, a low stop bit, and more traffic after the outcome is settled. These catch a receiver that samples off-centre, ignores the stop bit, or lets a settled `locked` or `error` be changed.

// File: rtl/autobaud_boot.sv
module autobaud_boot #(
  parameter int CNT_W    = 18,
  parameter int MIN_IDLE = 256,
  parameter int MIN_LOW  = 2048,
  parameter int TOL_SH   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rxd,
  output logic               txd,
  output logic               locked,
  output logic               error,
  output logic [CNT_W-4:0]   divisor
);
  localparam int DIV_W  = CNT_W - 3;
  localparam int IDLE_W = $clog2(MIN_IDLE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [3:0] {
    S_IDLE, S_LOW, S_TX, S_HUNT, S_WAIT, S_START, S_DATA, S_STOP, S_LOCK, S_FAIL
  } state_t;

  state_t            state;
  logic              rx_m, rx_s;
  logic [CNT_W-1:0]  cnt;
  logic [IDLE_W-1:0] idle_cnt;
  logic              have_first;
  logic [DIV_W-1:0]  div_first, div_q, tmr, div_new, diff;
  logic [3:0]        bitn;
  logic [7:0]        shreg;
  logic              run_ok, agree, tick, half_tick;

  assign div_new   = DIV_W'(({1'b0, cnt} + (CNT_W+1)'(4)) / (CNT_W+1)'(9));
  assign diff      = (div_new >= div_first) ? div_new - div_first : div_first - div_new;
  assign run_ok    = (cnt >= CNT_W'(MIN_LOW)) && (cnt != CNT_MAX);
  assign agree     = have_first && (diff <= (div_first >> TOL_SH));
  assign tick      = (tmr == div_q - DIV_W'(1));
  assign half_tick = (tmr == (div_q >> 1) - DIV_W'(1));

  assign txd     = !((state == S_TX) && (bitn < 4'd9));
  assign locked  = (state == S_LOCK);
  assign error   = (state == S_FAIL);
  assign divisor = div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      idle_cnt   <= '0;
      have_first <= 1'b0;
      div_first  <= '0;
      div_q      <= '0;
      tmr        <= '0;
      bitn       <= '0;
      shreg      <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (rx_s) begin
            if (idle_cnt != IDLE_W'(MIN_IDLE)) idle_cnt <= idle_cnt + IDLE_W'(1);
          end else if (idle_cnt == IDLE_W'(MIN_IDLE)) begin
            state <= S_LOW;
            cnt   <= CNT_W'(1);
          end else begin
            idle_cnt <= '0;
          end
        end
        S_LOW: begin
          if (!rx_s) begin
            if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
          end else begin
            idle_cnt <= IDLE_W'(1);
            state    <= S_IDLE;
            if (run_ok) begin
              if (agree) begin
                div_q <= div_new;
                state <= S_TX;
                tmr   <= '0;
                bitn  <= '0;
              end else begin
                div_first  <= div_new;
                have_first <= 1'b1;
              end
            end
          end
        end
        S_TX: begin
          tmr <= tick ? '0 : tmr + DIV_W'(1);
          if (tick) begin
            if (bitn == 4'd9) begin
              state <= S_HUNT;
              tmr   <= '0;
            end else begin
              bitn <= bitn + 4'd1;
            end
          end
        end
        S_HUNT: begin
          if (!rx_s) tmr <= '0;
          else if (tick) state <= S_WAIT;
          else tmr <= tmr + DIV_W'(1);
        end
        S_WAIT: begin
          if (!rx_s) begin
            state <= S_START;
            tmr   <= '0;
          end
        end
        S_START: begin
          if (half_tick) begin
            tmr  <= '0;
            bitn <= '0;
            state <= rx_s ? S_WAIT : S_DATA;
          end else begin
            tmr <= tmr + DIV_W'(1);
          end
        end
        S_DATA: begin
          tmr <= tick ? '0 : tmr + DIV_W'(1);
          if (tick) begin
            shreg <= {rx_s, shreg[7:1]};
            if (bitn == 4'd7) state <= S_STOP;
            else bitn <= bitn + 4'd1;
          end
        end
        S_STOP: begin
          tmr <= tick ? '0 : tmr + DIV_W'(1);
          if (tick) state <= (rx_s && shreg == 8'h55) ? S_LOCK : S_FAIL;
        end
        default: state <= state;
      endcase
    end
  end
endmodule

module autobaud_boot_chk #(
  parameter int DIV_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txd,
  input logic             locked,
  input logic             error,
  input logic [DIV_W-1:0] divisor
);
  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  p_error_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> (error && !locked));
  p_idle_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> txd);
  p_div_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor != '0) |=> $stable(divisor));
  p_lock_after_rate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(divisor) != '0) && txd);
endmodule

bind autobaud_boot autobaud_boot_chk #(.DIV_W(CNT_W-3)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .locked(locked), .error(error), .divisor(divisor)
);

// File: tb/autobaud_boot_tb.sv
module autobaud_boot_tb;
  localparam int CNT_W = 10;
  localparam int DIV_W = CNT_W - 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic txd, locked, error;
  logic [DIV_W-1:0] divisor;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int notice_cnt = 0;
  int last_len = 0;
  int cur_len = 0;

  always #10 clk = ~clk;

  autobaud_boot #(.CNT_W(CNT_W), .MIN_IDLE(8), .MIN_LOW(90), .TOL_SH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd),
    .locked(locked), .error(error), .divisor(divisor)
  );

  // vector: {first bit period, second bit period, confirm byte, stop ok, expected lock}
  localparam logic [25:0] VEC [8] = '{
    {8'd16, 8'd16, 8'h55, 1'b1, 1'b1},
    {8'd16, 8'd17, 8'h55, 1'b1, 1'b1},
    {8'd17, 8'd16, 8'h55, 1'b1, 1'b1},
    {8'd20, 8'd20, 8'h54, 1'b1, 1'b0},
    {8'd24, 8'd24, 8'h55, 1'b0, 1'b0},
    {8'd12, 8'd12, 8'hAA, 1'b1, 1'b0},
    {8'd30, 8'd30, 8'h55, 1'b1, 1'b1},
    {8'd12, 8'd12, 8'h55, 1'b1, 1'b1}
  };

  always @(negedge clk) begin
    if (!rst_n) begin
      notice_cnt <= 0; last_len <= 0; cur_len <= 0;
    end else if (!txd) begin
      cur_len <= cur_len + 1;
    end else if (cur_len != 0) begin
      last_len <= cur_len; notice_cnt <= notice_cnt + 1; cur_len <= 0;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic line);
    rxd = line;
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, input int p, input logic stop_ok);
    rxd = 1'b0; idle(p);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; idle(p); end
    rxd = stop_ok; idle(p);
    rxd = 1'b1; idle(p);
  endtask

  task automatic wait_notice(input int p);
    for (int i = 0; i < 3000; i++) begin
      if (notice_cnt != 0 && txd) break;
      idle(1);
    end
    idle(2 * p);
  endtask

  initial begin
    do_reset(1'b1);
    idle(2);
    check("R1 locked", locked, 0);
    check("R1 error", error, 0);
    check("R1 divisor", divisor, 0);
    check("R1 txd", txd, 1);

    foreach (VEC[k]) begin
      automatic int p1 = VEC[k][25:18];
      automatic int p2 = VEC[k][17:10];
      automatic logic [7:0] cb = VEC[k][9:2];
      automatic logic so = VEC[k][1];
      automatic int el = VEC[k][0];
      do_reset(1'b1);
      idle(32);
      send_byte(8'h00, p1, 1'b1);
      send_byte(8'h00, p2, 1'b1);
      wait_notice(p2);
      check("R2 R5 divisor", divisor, (9 * p2 + 4) / 9);
      check("R6 one notice", notice_cnt, 1);
      check("R6 notice length", last_len, 9 * p2);
      send_byte(cb, p2, so);
      idle(4 * p2);
      check("R7 locked", locked, el);
      check("R8 error", error, 1 - el);
    end

    do_reset(1'b1);
    idle(32);
    send_byte(8'h00, 16, 1'b1);
    send_byte(8'h00, 20, 1'b1);
    idle(60);
    check("R5 mismatch no accept", divisor, 0);
    check("R5 mismatch no notice", notice_cnt, 0);
    send_byte(8'h00, 20, 1'b1);
    wait_notice(20);
    check("R5 retry accepts", divisor, 20);

    do_reset(1'b1);
    idle(32);
    send_byte(8'h00, 16, 1'b1);
    rxd = 1'b0; idle(50); rxd = 1'b1; idle(32);
    send_byte(8'h00, 16, 1'b1);
    wait_notice(16);
    check("R4 short run ignored", divisor, 16);

    do_reset(1'b1);
    idle(32);
    send_byte(8'h00, 16, 1'b1);
    rxd = 1'b0; idle(1100); rxd = 1'b1; idle(32);
    send_byte(8'h00, 16, 1'b1);
    wait_notice(16);
    check("R4 saturated run ignored", divisor, 16);

    do_reset(1'b0);
    idle(144);
    rxd = 1'b1; idle(32);
    send_byte(8'h00, 16, 1'b1);
    idle(40);
    check("R3 unarmed run not measured", divisor, 0);
    check("R3 no early notice", notice_cnt, 0);
    send_byte(8'h00, 16, 1'b1);
    wait_notice(16);
    check("R3 accept after armed pair", divisor, 16);
    send_byte(8'h55, 16, 1'b1);
    idle(64);
    check("R7 lock after armed pair", locked, 1);
    send_byte(8'h00, 16, 1'b1);
    send_byte(8'h00, 18, 1'b1);
    send_byte(8'h54, 16, 1'b1);
    idle(64);
    check("R9 lock held", locked, 1);
    check("R9 no error after lock", error, 0);
    check("R9 divisor held", divisor, 16);
    check("R9 no second notice", notice_cnt, 1);

    do_reset(1'b1);
    idle(32);
    send_byte(8'h00, 14, 1'b1);
    send_byte(8'h00, 14, 1'b1);
    wait_notice(14);
    send_byte(8'h33, 14, 1'b1);
    idle(40);
    check("R8 error on wrong byte", error, 1);
    send_byte(8'h55, 14, 1'b1);
    idle(60);
    check("R9 error held", error, 1);
    check("R9 no lock after error", locked, 0);
    check("R9 txd idle after error", txd, 1);

    do_reset(1'b1);
    idle(2);
    check("R1 reset clears error", error, 0);
    check("R1 reset clears divisor", divisor, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule